// File: doc/BRIEF.md
# Predicated Data-Processing ALU with Operand Shifter

This block carries out one 32-bit data-processing operation per cycle. The operation is predicated: it runs only if a 4-bit condition code is satisfied by the N, Z, C and V flags. These flags are held in the block's own flag register. The second operand comes from one of two sources. The first is an 8-bit constant rotated right by an even amount. The second is a register value passed through a barrel shifter, with a shift amount taken either from a 5-bit field or from the low byte of a second register.

The result and its write-enable are combinational. Flag updates are registered on the rising clock edge. The updated flags take part in the condition and carry-in of the next operation. Logical operations take their carry from the shifter. Arithmetic operations take it from the adder. Compare and test operations change only the flags.

Top module: `cond_alu`

## Requirements
- R1: The condition encodings are: 0 Z, 1 !Z, 2 C, 3 !C, 4 N, 5 !N, 6 V, 7 !V, 8 C&!Z, 9 !C|Z, 10 N==V, 11 N!=V, 12 !Z&(N==V), 13 Z|(N!=V) and 14 always. They are evaluated against the registered flags `flags` = {N,Z,C,V} (bit 3 down to bit 0), and `cond_pass` reports the outcome.
- R2: Condition code 15 never passes.
- R3: When the condition fails, `wr_en` is 0 and the flags keep their value at the next edge. This holds for compare and test operations too.
- R4: With `set_flags`=0, a passing non-compare operation drives `wr_en`=1 and leaves the flags unchanged.
- R5: Opcodes 8 to 11 (TST, TEQ, CMP, CMN) update the flags whenever their condition passes, whatever `set_flags` is, and never assert `wr_en`.
- R6: The opcode encodings are: 0 AND, 1 EOR, 2 SUB, 3 RSB (b-a), 4 ADD, 5 ADC (a+b+C), 6 SBC (a-b+C-1), 7 RSC (b-a+C-1), 8 TST (and), 9 TEQ (xor), 10 CMP (sub), 11 CMN (add), 12 ORR, 13 MOV (b), 14 BIC (a&~b) and 15 MVN (~b). Here b is the shifted second operand.
- R7: On a flag update, N equals result bit 31 and Z is set when the result is zero. For arithmetic operations, C is the adder carry-out (for subtraction, 1 means no borrow) and V is signed overflow.
- R8: For logical operations (0, 1, 8, 9, 12–15), C is the shifter carry-out and V keeps its previous value.
- R9: When `op2_is_imm`=1, the second operand is `imm8` rotated right by 2×`imm_rot`. The shifter carry is C when `imm_rot`=0; otherwise it is bit 31 of the rotated value.
- R10: Shift kinds are 0 LSL, 1 LSR, 2 ASR, 3 ROR and 4 RRX. For an amount n from 1 to 31, the register operand is shifted by n, and the carry is the last bit shifted out (for ROR, the new bit 31). An amount of 0 leaves the operand unchanged and the carry equal to C.
- R11: When `shift_by_reg`=1, the amount is `shift_amt_reg` (0..255). A zero amount leaves the operand and the carry unchanged. For LSL and LSR, 32 gives 0 with carry equal to bit 0 (LSL) or bit 31 (LSR), and above 32 gives 0 with carry 0. ASR at 32 or more gives 32 copies of the sign bit with carry equal to the sign. ROR uses the amount modulo 32; a nonzero multiple of 32 leaves the value unchanged with carry equal to bit 31.
- R12: RRX ignores the amount. It yields {C, b[31:1]} with carry b[0].
- R13: A synchronous active-high `rst` clears the flags to 0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cond | input | 4 | Condition code |
| opcode | input | 4 | Operation select |
| set_flags | input | 1 | Request flag update |
| op_a | input | 32 | First operand |
| op2_is_imm | input | 1 | Second operand is rotated constant |
| imm8 | input | 8 | Constant value |
| imm_rot | input | 4 | Constant rotate, in units of two bits |
| op_b | input | 32 | Register second operand |
| shift_kind | input | 3 | Shift type |
| shift_by_reg | input | 1 | Take amount from shift_amt_reg |
| shift_imm | input | 5 | Immediate shift amount |
| shift_amt_reg | input | 8 | Low byte of shift-amount register |
| result | output | 32 | Operation result |
| wr_en | output | 1 | Result is to be written |
| cond_pass | output | 1 | Condition satisfied |
| flags | output | 4 | Registered {N,Z,C,V} |

## Verification
The condition veto and the flag update of a compare can land in the same cycle. The bench provokes this with a compare under a condition that the current flags reject; the test must show the flags holding. The shifter's use of the old C as carry-in and the flag write that replaces C can also coincide. This is provoked with flag-setting moves that use a zero shift, a zero-rotate immediate and RRX. In each case the new C must be the value derived from the old C, observed one edge later.

// File: rtl/cond_alu_pkg.sv
`timescale 1ns/1ps
package cond_alu_pkg;
  typedef enum logic [3:0] {
    OP_AND = 4'd0, OP_EOR = 4'd1, OP_SUB = 4'd2, OP_RSB = 4'd3,
    OP_ADD = 4'd4, OP_ADC = 4'd5, OP_SBC = 4'd6, OP_RSC = 4'd7,
    OP_TST = 4'd8, OP_TEQ = 4'd9, OP_CMP = 4'd10, OP_CMN = 4'd11,
    OP_ORR = 4'd12, OP_MOV = 4'd13, OP_BIC = 4'd14, OP_MVN = 4'd15
  } alu_op_e;

  typedef enum logic [2:0] {
    SH_LSL = 3'd0, SH_LSR = 3'd1, SH_ASR = 3'd2, SH_ROR = 3'd3, SH_RRX = 3'd4
  } shift_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } nzcv_t;
endpackage

// File: rtl/cond_check.sv
`timescale 1ns/1ps
module cond_check
  import cond_alu_pkg::*;
(
  input  logic [3:0] code,
  input  nzcv_t      fl,
  output logic       pass
);
  always_comb begin
    case (code)
      4'd0:  pass = fl.z;
      4'd1:  pass = !fl.z;
      4'd2:  pass = fl.c;
      4'd3:  pass = !fl.c;
      4'd4:  pass = fl.n;
      4'd5:  pass = !fl.n;
      4'd6:  pass = fl.v;
      4'd7:  pass = !fl.v;
      4'd8:  pass = fl.c && !fl.z;
      4'd9:  pass = !fl.c || fl.z;
      4'd10: pass = (fl.n == fl.v);
      4'd11: pass = (fl.n != fl.v);
      4'd12: pass = !fl.z && (fl.n == fl.v);
      4'd13: pass = fl.z || (fl.n != fl.v);
      4'd14: pass = 1'b1;
      default: pass = 1'b0;
    endcase
  end

  // R2: the reserved code must never let an operation through
  always_comb begin
    if (code == 4'hF) begin
      assert_never_code_R2: assert (!pass);
    end
  end
endmodule

// File: rtl/operand_shifter.sv
`timescale 1ns/1ps
module operand_shifter
  import cond_alu_pkg::*;
#(
  parameter int W     = 32,
  parameter int IMM_W = 8,
  parameter int ROT_W = 4,
  parameter int AMT_W = 8
) (
  input  logic              use_imm,
  input  logic [IMM_W-1:0]  imm,
  input  logic [ROT_W-1:0]  rot,
  input  logic [W-1:0]      val,
  input  logic [2:0]        kind,
  input  logic              by_reg,
  input  logic [$clog2(W)-1:0] amt_imm,
  input  logic [AMT_W-1:0]  amt_reg,
  input  logic              c_in,
  output logic [W-1:0]      op2,
  output logic              c_out
);
  localparam int SH_W = $clog2(W);
  localparam logic [AMT_W-1:0] W_AMT = AMT_W'(W);

  function automatic logic [W-1:0] ror_f(input logic [W-1:0] x, input logic [SH_W-1:0] k);
    logic [SH_W-1:0] kn;
    kn = -k;
    return (x >> k) | (x << kn);
  endfunction

  logic [AMT_W-1:0] amt, amt_asr;
  logic [W:0]       lsl_w, lsr_w, asr_w;
  logic [W-1:0]     imm_rot_v, ror_v;
  logic [SH_W-1:0]  ror_k;
  logic [W-1:0]     sh_v;
  logic             sh_c;

  always_comb begin
    amt       = by_reg ? amt_reg : AMT_W'(amt_imm);
    amt_asr   = (amt > W_AMT) ? W_AMT : amt;
    lsl_w     = {1'b0, val} << amt;
    lsr_w     = {val, 1'b0} >> amt;
    asr_w     = $signed({val, 1'b0}) >>> amt_asr;
    ror_k     = amt[SH_W-1:0];
    ror_v     = ror_f(val, ror_k);
    imm_rot_v = ror_f(W'(imm), SH_W'({rot, 1'b0}));

    sh_v = val;
    sh_c = c_in;
    if (shift_e'(kind) == SH_RRX) begin
      sh_v = {c_in, val[W-1:1]};
      sh_c = val[0];
    end else if (amt != '0) begin
      case (shift_e'(kind))
        SH_LSR: begin
          sh_v = (amt > W_AMT) ? '0   : lsr_w[W:1];
          sh_c = (amt > W_AMT) ? 1'b0 : lsr_w[0];
        end
        SH_ASR: begin
          sh_v = asr_w[W:1];
          sh_c = asr_w[0];
        end
        SH_ROR: begin
          sh_v = ror_v;
          sh_c = ror_v[W-1];
        end
        default: begin
          sh_v = (amt > W_AMT) ? '0   : lsl_w[W-1:0];
          sh_c = (amt > W_AMT) ? 1'b0 : lsl_w[W];
        end
      endcase
    end

    if (use_imm) begin
      op2   = imm_rot_v;
      c_out = (rot == '0) ? c_in : imm_rot_v[W-1];
    end else begin
      op2   = sh_v;
      c_out = sh_c;
    end
  end
endmodule

// File: rtl/alu_core.sv
`timescale 1ns/1ps
module alu_core
  import cond_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  alu_op_e      op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         c_in,
  input  logic         v_in,
  input  logic         sh_c,
  output logic [W-1:0] res,
  output nzcv_t        nxt,
  output logic         is_test
);
  logic [W-1:0] x, y, lg;
  logic         cin, arith;
  logic [W:0]   sum;

  always_comb begin
    x = a; y = b; cin = 1'b0; arith = 1'b1;
    case (op)
      OP_SUB, OP_CMP: begin y = ~b; cin = 1'b1; end
      OP_RSB:         begin x = b; y = ~a; cin = 1'b1; end
      OP_ADC:         cin = c_in;
      OP_SBC:         begin y = ~b; cin = c_in; end
      OP_RSC:         begin x = b; y = ~a; cin = c_in; end
      OP_ADD, OP_CMN: cin = 1'b0;
      default:        arith = 1'b0;
    endcase
    sum = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, cin};

    case (op)
      OP_AND, OP_TST: lg = a & b;
      OP_EOR, OP_TEQ: lg = a ^ b;
      OP_ORR:         lg = a | b;
      OP_BIC:         lg = a & ~b;
      OP_MVN:         lg = ~b;
      default:        lg = b;
    endcase

    res     = arith ? sum[W-1:0] : lg;
    nxt.n   = res[W-1];
    nxt.z   = (res == '0);
    nxt.c   = arith ? sum[W] : sh_c;
    nxt.v   = arith ? ((x[W-1] == y[W-1]) && (sum[W-1] != x[W-1])) : v_in;
    is_test = (op == OP_TST) || (op == OP_TEQ) || (op == OP_CMP) || (op == OP_CMN);
  end
endmodule

// File: rtl/cond_alu.sv
`timescale 1ns/1ps
module cond_alu
  import cond_alu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 8,
  parameter int ROT_W  = 4,
  parameter int AMT_W  = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [3:0]                cond,
  input  logic [3:0]                opcode,
  input  logic                      set_flags,
  input  logic [DATA_W-1:0]         op_a,
  input  logic                      op2_is_imm,
  input  logic [IMM_W-1:0]          imm8,
  input  logic [ROT_W-1:0]          imm_rot,
  input  logic [DATA_W-1:0]         op_b,
  input  logic [2:0]                shift_kind,
  input  logic                      shift_by_reg,
  input  logic [$clog2(DATA_W)-1:0] shift_imm,
  input  logic [AMT_W-1:0]          shift_amt_reg,
  output logic [DATA_W-1:0]         result,
  output logic                      wr_en,
  output logic                      cond_pass,
  output logic [3:0]                flags
);
  nzcv_t             flags_q, nxt;
  logic [DATA_W-1:0] op2;
  logic              sh_c, is_test, upd;

  cond_check u_cond (
    .code (cond),
    .fl   (flags_q),
    .pass (cond_pass)
  );

  operand_shifter #(.W(DATA_W), .IMM_W(IMM_W), .ROT_W(ROT_W), .AMT_W(AMT_W)) u_shift (
    .use_imm (op2_is_imm),
    .imm     (imm8),
    .rot     (imm_rot),
    .val     (op_b),
    .kind    (shift_kind),
    .by_reg  (shift_by_reg),
    .amt_imm (shift_imm),
    .amt_reg (shift_amt_reg),
    .c_in    (flags_q.c),
    .op2     (op2),
    .c_out   (sh_c)
  );

  alu_core #(.W(DATA_W)) u_alu (
    .op      (alu_op_e'(opcode)),
    .a       (op_a),
    .b       (op2),
    .c_in    (flags_q.c),
    .v_in    (flags_q.v),
    .sh_c    (sh_c),
    .res     (result),
    .nxt     (nxt),
    .is_test (is_test)
  );

  assign upd   = cond_pass && (set_flags || is_test);
  assign wr_en = cond_pass && !is_test;
  assign flags = flags_q;

  always_ff @(posedge clk) begin
    if (rst)      flags_q <= '0;
    else if (upd) flags_q <= nxt;
  end

  // R3: a rejected condition freezes the flags
  assert_fail_holds_flags_R3: assert property (@(posedge clk) disable iff (rst)
    !cond_pass |=> $stable(flags));

  // R4: without a flag request an ordinary operation leaves the flags alone
  assert_no_s_holds_flags_R4: assert property (@(posedge clk) disable iff (rst)
    (cond_pass && !set_flags && (opcode[3:2] != 2'b10)) |=> $stable(flags));

  // R5: compare and test opcodes never request a write
  assert_test_no_write_R5: assert property (@(posedge clk) disable iff (rst)
    (opcode[3:2] == 2'b10) |-> !wr_en);

  // R7: Z tracks a zero result of the updating operation
  assert_z_tracks_result_R7: assert property (@(posedge clk) disable iff (rst)
    upd |=> (flags[2] == ($past(result) == '0)));

  // R8: logical operations keep V
  assert_logic_keeps_v_R8: assert property (@(posedge clk) disable iff (rst)
    (upd && !(opcode inside {4'd2, 4'd3, 4'd4, 4'd5, 4'd6, 4'd7, 4'd10, 4'd11}))
    |=> (flags[0] == $past(flags[0])));
endmodule

// File: tb/cond_alu_test.sv
`timescale 1ns/1ps
module cond_alu_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  cond = 4'd14, opcode = 4'd0;
  logic        set_flags = 1'b0;
  logic [31:0] op_a = '0, op_b = '0;
  logic        op2_is_imm = 1'b0;
  logic [7:0]  imm8 = '0;
  logic [3:0]  imm_rot = '0;
  logic [2:0]  shift_kind = '0;
  logic        shift_by_reg = 1'b0;
  logic [4:0]  shift_imm = '0;
  logic [7:0]  shift_amt_reg = '0;
  logic [31:0] result;
  logic        wr_en, cond_pass;
  logic [3:0]  flags;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  cond_alu uut (
    .clk(clk), .rst(rst), .cond(cond), .opcode(opcode), .set_flags(set_flags),
    .op_a(op_a), .op2_is_imm(op2_is_imm), .imm8(imm8), .imm_rot(imm_rot),
    .op_b(op_b), .shift_kind(shift_kind), .shift_by_reg(shift_by_reg),
    .shift_imm(shift_imm), .shift_amt_reg(shift_amt_reg),
    .result(result), .wr_en(wr_en), .cond_pass(cond_pass), .flags(flags)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic setop(input logic [3:0] c, input logic [3:0] o, input logic s,
                       input logic [31:0] a, input logic [31:0] b);
    cond = c; opcode = o; set_flags = s; op_a = a; op_b = b;
    op2_is_imm = 1'b0; imm8 = '0; imm_rot = '0;
    shift_kind = 3'd0; shift_by_reg = 1'b0; shift_imm = '0; shift_amt_reg = '0;
  endtask

  task automatic shf(input logic [2:0] k, input logic byreg, input logic [7:0] n);
    shift_kind = k; shift_by_reg = byreg;
    if (byreg) shift_amt_reg = n; else shift_imm = n[4:0];
  endtask

  task automatic imm(input logic [7:0] v, input logic [3:0] r);
    op2_is_imm = 1'b1; imm8 = v; imm_rot = r;
  endtask

  // outputs settle 1 ns after the inputs; flags appear after the next edge
  task automatic run(input string req, input logic [31:0] er, input logic ew, input logic [3:0] ef);
    #1;
    chk(req, "result", result, er);
    chk(req, "wr_en", {31'b0, wr_en}, {31'b0, ew});
    @(posedge clk); #1;
    chk(req, "flags", {28'b0, flags}, {28'b0, ef});
  endtask

  task automatic t_reset;
    chk("R13", "flags after reset", {28'b0, flags}, 32'h0);
  endtask

  task automatic t_cond;
    setop(4'd14, 4'd10, 0, 5, 5);           run("R5", 0, 0, 4'b0110);
    setop(4'd0, 4'd4, 0, 1, 2);             run("R1", 3, 1, 4'b0110);
    setop(4'd1, 4'd4, 1, 1, 2);             run("R3", 3, 0, 4'b0110);
    setop(4'd8, 4'd4, 0, 1, 2);             run("R1", 3, 0, 4'b0110);
    setop(4'd9, 4'd4, 0, 1, 2);             run("R1", 3, 1, 4'b0110);
    setop(4'd15, 4'd4, 1, 1, 2);            run("R2", 3, 0, 4'b0110);
    setop(4'd1, 4'd10, 0, 3, 5);            run("R3", 32'hFFFFFFFE, 0, 4'b0110);
    setop(4'd14, 4'd10, 0, 3, 5);           run("R1", 32'hFFFFFFFE, 0, 4'b1000);
    setop(4'd10, 4'd13, 0, 0, 7);           run("R1", 7, 0, 4'b1000);
    setop(4'd11, 4'd13, 0, 0, 7);           run("R1", 7, 1, 4'b1000);
    setop(4'd4, 4'd13, 0, 0, 7);            run("R1", 7, 1, 4'b1000);
    setop(4'd3, 4'd13, 0, 0, 7);            run("R1", 7, 1, 4'b1000);
    setop(4'd2, 4'd13, 0, 0, 7);            run("R1", 7, 0, 4'b1000);
    setop(4'd14, 4'd10, 0, 32'h80000000, 1); run("R7", 32'h7FFFFFFF, 0, 4'b0011);
    setop(4'd6, 4'd13, 0, 0, 7);            run("R1", 7, 1, 4'b0011);
    setop(4'd12, 4'd13, 0, 0, 7);           run("R1", 7, 0, 4'b0011);
    setop(4'd13, 4'd13, 0, 0, 7);           run("R1", 7, 1, 4'b0011);
    setop(4'd5, 4'd13, 0, 0, 7);            run("R1", 7, 1, 4'b0011);
    setop(4'd7, 4'd13, 0, 0, 7);            run("R1", 7, 0, 4'b0011);
  endtask

  task automatic t_sflag;
    setop(4'd14, 4'd4, 0, 32'hFFFFFFFF, 1); run("R4", 0, 1, 4'b0011);
    setop(4'd14, 4'd4, 1, 32'hFFFFFFFF, 1); run("R7", 0, 1, 4'b0110);
    setop(4'd14, 4'd4, 1, 32'h7FFFFFFF, 1); run("R7", 32'h80000000, 1, 4'b1001);
    setop(4'd14, 4'd2, 1, 0, 1);            run("R7", 32'hFFFFFFFF, 1, 4'b1000);
    setop(4'd14, 4'd2, 1, 5, 3);            run("R7", 2, 1, 4'b0010);
  endtask

  task automatic t_compare;
    setop(4'd14, 4'd8, 0, 32'hF0, 32'h0F);  run("R5", 0, 0, 4'b0110);
    setop(4'd14, 4'd9, 0, 32'hFF, 32'hFF);  run("R5", 0, 0, 4'b0110);
    setop(4'd14, 4'd11, 0, 32'h7FFFFFFF, 1); run("R5", 32'h80000000, 0, 4'b1001);
  endtask

  task automatic t_arith;
    setop(4'd14, 4'd10, 0, 5, 5);           run("R6", 0, 0, 4'b0110);
    setop(4'd14, 4'd5, 0, 1, 2);            run("R6", 4, 1, 4'b0110);
    setop(4'd14, 4'd6, 0, 10, 3);           run("R6", 7, 1, 4'b0110);
    setop(4'd14, 4'd7, 0, 1, 10);           run("R6", 9, 1, 4'b0110);
    setop(4'd14, 4'd10, 0, 3, 5);           run("R6", 32'hFFFFFFFE, 0, 4'b1000);
    setop(4'd14, 4'd5, 0, 1, 2);            run("R6", 3, 1, 4'b1000);
    setop(4'd14, 4'd6, 0, 10, 3);           run("R6", 6, 1, 4'b1000);
    setop(4'd14, 4'd7, 0, 1, 10);           run("R6", 8, 1, 4'b1000);
    setop(4'd14, 4'd2, 0, 10, 3);           run("R6", 7, 1, 4'b1000);
    setop(4'd14, 4'd3, 0, 3, 10);           run("R6", 7, 1, 4'b1000);
    setop(4'd14, 4'd0, 0, 32'hFF00FF00, 32'h0FF00FF0);  run("R6", 32'h0F000F00, 1, 4'b1000);
    setop(4'd14, 4'd1, 0, 32'hFF00FF00, 32'h0FF00FF0);  run("R6", 32'hF0F0F0F0, 1, 4'b1000);
    setop(4'd14, 4'd12, 0, 32'hFF00FF00, 32'h0FF00FF0); run("R6", 32'hFFF0FFF0, 1, 4'b1000);
    setop(4'd14, 4'd13, 0, 32'hFF00FF00, 32'h0FF00FF0); run("R6", 32'h0FF00FF0, 1, 4'b1000);
    setop(4'd14, 4'd14, 0, 32'hFF00FF00, 32'h0FF00FF0); run("R6", 32'hF000F000, 1, 4'b1000);
    setop(4'd14, 4'd15, 0, 32'hFF00FF00, 32'h0FF00FF0); run("R6", 32'hF00FF00F, 1, 4'b1000);
  endtask

  task automatic t_logic;
    setop(4'd14, 4'd10, 0, 32'h80000000, 1); run("R8", 32'h7FFFFFFF, 0, 4'b0011);
    setop(4'd14, 4'd0, 1, 32'h80000000, 32'h80000000); shf(3'd0, 0, 1);
    run("R8", 0, 1, 4'b0111);
    setop(4'd14, 4'd1, 1, 0, 3); shf(3'd1, 0, 1);
    run("R8", 1, 1, 4'b0011);
    setop(4'd14, 4'd14, 1, 32'hFFFFFFFF, 32'h0000FFFF); shf(3'd0, 0, 16);
    run("R8", 32'h0000FFFF, 1, 4'b0001);
  endtask

  task automatic t_imm;
    setop(4'd14, 4'd13, 1, 0, 0); imm(8'hFF, 4'd4);  run("R9", 32'hFF000000, 1, 4'b1011);
    setop(4'd14, 4'd13, 0, 0, 0); imm(8'h3F, 4'd1);  run("R9", 32'hC000000F, 1, 4'b1011);
    setop(4'd14, 4'd13, 0, 0, 0); imm(8'h01, 4'd15); run("R9", 32'h00000004, 1, 4'b1011);
    setop(4'd14, 4'd4, 0, 1, 0);  imm(8'hFF, 4'd0);  run("R9", 32'h00000100, 1, 4'b1011);
    setop(4'd14, 4'd13, 1, 0, 0); imm(8'h05, 4'd0);  run("R9", 5, 1, 4'b0011);
    setop(4'd14, 4'd10, 0, 3, 5);                    run("R9", 32'hFFFFFFFE, 0, 4'b1000);
    setop(4'd14, 4'd13, 1, 0, 0); imm(8'h00, 4'd0);  run("R9", 0, 1, 4'b0100);
  endtask

  task automatic t_shift_imm;
    setop(4'd14, 4'd13, 0, 0, 32'h80000001); shf(3'd0, 0, 4); run("R10", 32'h00000010, 1, 4'b0100);
    setop(4'd14, 4'd13, 0, 0, 32'h80000001); shf(3'd1, 0, 4); run("R10", 32'h08000000, 1, 4'b0100);
    setop(4'd14, 4'd13, 0, 0, 32'h80000001); shf(3'd2, 0, 4); run("R10", 32'hF8000000, 1, 4'b0100);
    setop(4'd14, 4'd13, 0, 0, 32'h80000001); shf(3'd3, 0, 4); run("R10", 32'h18000000, 1, 4'b0100);
    setop(4'd14, 4'd13, 0, 0, 32'h80000001); shf(3'd1, 0, 0); run("R10", 32'h80000001, 1, 4'b0100);
    setop(4'd14, 4'd13, 1, 0, 32'h80000001); shf(3'd2, 0, 0); run("R10", 32'h80000001, 1, 4'b1000);
    setop(4'd14, 4'd13, 1, 0, 32'h80000001); shf(3'd0, 0, 1); run("R10", 32'h00000002, 1, 4'b0010);
    setop(4'd14, 4'd13, 1, 0, 32'h00000001); shf(3'd3, 0, 1); run("R10", 32'h80000000, 1, 4'b1010);
  endtask

  task automatic t_shift_reg;
    setop(4'd14, 4'd13, 0, 0, 32'h80000001); shf(3'd0, 1, 4);  run("R11", 32'h00000010, 1, 4'b1010);
    setop(4'd14, 4'd13, 1, 0, 32'h80000001); shf(3'd0, 1, 32); run("R11", 0, 1, 4'b0110);
    setop(4'd14, 4'd13, 1, 0, 32'h80000001); shf(3'd1, 1, 33); run("R11", 0, 1, 4'b0100);
    setop(4'd14, 4'd13, 1, 0, 32'h80000001); shf(3'd2, 1, 40); run("R11", 32'hFFFFFFFF, 1, 4'b1010);
    setop(4'd14, 4'd13, 1, 0, 32'h80000001); shf(3'd3, 1, 36); run("R11", 32'h18000000, 1, 4'b0000);
    setop(4'd14, 4'd13, 1, 0, 32'h80000001); shf(3'd1, 1, 0);  run("R11", 32'h80000001, 1, 4'b1000);
    setop(4'd14, 4'd13, 1, 0, 32'h80000001); shf(3'd3, 1, 32); run("R11", 32'h80000001, 1, 4'b1010);
    setop(4'd14, 4'd13, 1, 0, 32'h80000001); shf(3'd1, 1, 32); run("R11", 0, 1, 4'b0110);
  endtask

  task automatic t_rrx;
    setop(4'd14, 4'd10, 0, 5, 5);            run("R12", 0, 0, 4'b0110);
    setop(4'd14, 4'd13, 1, 0, 2); shf(3'd4, 0, 0); run("R12", 32'h80000001, 1, 4'b1000);
    setop(4'd14, 4'd13, 1, 0, 3); shf(3'd4, 0, 7); run("R12", 32'h00000001, 1, 4'b0010);
  endtask

  initial begin
    #100000;
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog (all requirements): actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    t_reset();
    t_cond();
    t_sflag();
    t_compare();
    t_arith();
    t_logic();
    t_imm();
    t_shift_imm();
    t_shift_reg();
    t_rrx();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule